// File: doc/BRIEF.md
# Processor Clock, Ready and Reset Generator

This block turns one oscillator-domain clock into the timing signals a small processor bus needs. A select input picks the timing source: the free-running input clock itself (crystal path) or an external frequency input modelled as a one-cycle enable pulse per source period. The chosen source is divided by three to form the processor clock, which is high for one source period and low for two. A peripheral clock at half that rate, with an even duty cycle, is formed beside it. A copy of the source rate is also brought out as a one-cycle pulse per source period.

The block also conditions two control signals for the processor. Two ready request pairs are combined into one READY output. Each pair is a ready line plus an active-low enable that qualifies it. READY only moves on the high-to-low edge of the processor clock, so the processor never sees it change while sampling. An active-low reset request is synchronised through a register chain and drives an active-high RESET. A counter stretches RESET so that it always covers a minimum number of processor clock periods. Every output is a register in the oscillator clock domain. An asynchronous power-on input initialises that state.

Top module: `clkgen_ready_reset`

## Requirements
- R1: `fsel_i` = 0 selects the crystal path (one source period per `clk_i` cycle) and 1 selects the external path (one source period per `efi_en_i` pulse). A change of `fsel_i` is adopted only on the source period in which `cpu_clk_o` rises, so a processor clock high phase always lasts one whole period of a single source.
- R2: `cpu_clk_o` rises on every third source period and falls one source period later. In crystal mode it is high for 1 of every 3 `clk_i` cycles. With an enable pulse every 2 cycles it is high for 2 of every 6 cycles.
- R3: `pclk_o` toggles only in the cycle in which `cpu_clk_o` rises, and on every such rise. This gives 1/6 of the source rate with 50% duty.
- R4: `osc_o` is high for one cycle per source period, one cycle after it. In crystal mode it is constantly high.
- R5: READY's target value is (`rdy1_i` AND NOT `aen1_ni`) OR (`rdy2_i` AND NOT `aen2_ni`).
- R6: `ready_o` changes only in the cycle in which `cpu_clk_o` falls.
- R7: Three `clk_i` rising edges after `res_ni` goes low, `reset_o` is high: two edges cross the synchroniser and one edge registers the output. After two edges it is not yet high when it was low before.
- R8: Count the rising edges of `cpu_clk_o` from the third `clk_i` edge after `res_ni` returns high. `reset_o` falls in the cycle of the 4th such edge (parameter `RST_CYC`). This holds for a one-cycle request too, and `reset_o` stays high while `res_ni` stays low.
- R9: While `arst_ni` is low, `reset_o` is 1 and `cpu_clk_o`, `pclk_o`, `ready_o` and `osc_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| arst_ni | input | 1 | Asynchronous power-on initialisation, active low |
| fsel_i | input | 1 | Source select: 0 crystal, 1 external |
| efi_en_i | input | 1 | External source, one pulse per source period |
| rdy1_i | input | 1 | Ready line of pair 1 |
| aen1_ni | input | 1 | Active-low qualifier of pair 1 |
| rdy2_i | input | 1 | Ready line of pair 2 |
| aen2_ni | input | 1 | Active-low qualifier of pair 2 |
| res_ni | input | 1 | Reset request, active low, asynchronous |
| osc_o | output | 1 | Source-rate pulse |
| cpu_clk_o | output | 1 | Processor clock, 1/3 duty |
| pclk_o | output | 1 | Peripheral clock, 50% duty |
| ready_o | output | 1 | Combined ready |
| reset_o | output | 1 | Processor reset, active high |

## Verification
The clock outputs are checked over windows of several periods as run lengths: high width, rise-to-rise distance, and a `pclk_o` toggle on each `cpu_clk_o` rise. The first partial period after each mode change is skipped. READY values are checked only after eight cycles of stable inputs, which exceeds the one-cycle capture plus the wait for the next falling processor clock. A separate walk confirms that the change lands exactly in a falling-edge cycle. RESET is sampled after exactly two and three `clk_i` edges from the request. Its release is counted in processor clock rises, starting from the third edge after the request goes away.

// File: rtl/clkgen_ready_reset.sv
module clkgen_ready_reset #(
  parameter int RST_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic fsel_i,
  input  logic efi_en_i,
  input  logic rdy1_i,
  input  logic aen1_ni,
  input  logic rdy2_i,
  input  logic aen2_ni,
  input  logic res_ni,
  output logic osc_o,
  output logic cpu_clk_o,
  output logic pclk_o,
  output logic ready_o,
  output logic reset_o
);
  localparam int CW = $clog2(RST_CYC + 1);

  logic                   sel_q;
  logic [1:0]             phase_q;
  logic                   tick, cpu_rise, cpu_fall;
  logic                   req_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   res_s;
  logic [CW-1:0]          cnt_q;

  assign tick     = sel_q ? efi_en_i : 1'b1;
  assign cpu_rise = tick && (phase_q == 2'd2);
  assign cpu_fall = tick && (phase_q == 2'd0);
  assign res_s    = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sel_q     <= 1'b0;
      phase_q   <= 2'd2;
      cpu_clk_o <= 1'b0;
      pclk_o    <= 1'b0;
      osc_o     <= 1'b0;
    end else begin
      osc_o <= tick;
      if (tick) phase_q <= (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
      if (cpu_rise) begin
        cpu_clk_o <= 1'b1;
        pclk_o    <= ~pclk_o;
        sel_q     <= fsel_i;
      end else if (cpu_fall) begin
        cpu_clk_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      req_q   <= 1'b0;
      ready_o <= 1'b0;
    end else begin
      req_q <= (rdy1_i & ~aen1_ni) | (rdy2_i & ~aen2_ni);
      if (cpu_fall) ready_o <= req_q;
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC_STAGES-2:0], res_ni};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      reset_o <= 1'b1;
      cnt_q   <= '0;
    end else if (!res_s) begin
      reset_o <= 1'b1;
      cnt_q   <= '0;
    end else if (reset_o && cpu_rise) begin
      if (cnt_q == CW'(RST_CYC - 1)) reset_o <= 1'b0;
      else                           cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R1: source choice only moves together with a processor clock rise
  a_r1_sel_at_period: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !$stable(sel_q) |-> $rose(cpu_clk_o));
  // R2: high phase ends at the next source period
  a_r2_high_one_period: assert property (@(posedge clk_i) disable iff (!arst_ni)
    (cpu_clk_o && tick) |=> !cpu_clk_o);
  // R3: peripheral clock moves only with processor clock rise
  a_r3_pclk_on_rise: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !$stable(pclk_o) |-> $rose(cpu_clk_o));
  // R6: ready moves only on processor clock fall
  a_r6_ready_on_fall: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !$stable(ready_o) |-> $fell(cpu_clk_o));
  // R7: synchronised request forces reset next cycle
  a_r7_reset_follows: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !res_s |=> reset_o);
  // R8: release happens on a processor clock rise
  a_r8_release_on_rise: assert property (@(posedge clk_i) disable iff (!arst_ni)
    $fell(reset_o) |-> $rose(cpu_clk_o));
endmodule

// File: tb/clkgen_ready_reset_tb.sv
module clkgen_ready_reset_tb_top;
  logic clk = 0, arst_n = 0, fsel = 0, efi_en = 0, efi_run = 0;
  logic rdy1 = 0, aen1_n = 1, rdy2 = 0, aen2_n = 1, res_n = 0;
  logic osc, cpu, pclk, rdy, rst;
  int n_chk = 0, n_fail = 0;

  clkgen_ready_reset dut_i (
    .clk_i(clk), .arst_ni(arst_n), .fsel_i(fsel), .efi_en_i(efi_en),
    .rdy1_i(rdy1), .aen1_ni(aen1_n), .rdy2_i(rdy2), .aen2_ni(aen2_n),
    .res_ni(res_n), .osc_o(osc), .cpu_clk_o(cpu), .pclk_o(pclk),
    .ready_o(rdy), .reset_o(rst));

  always #2 clk = ~clk;

  always begin
    @(posedge clk);
    #1 efi_en = efi_run ? ~efi_en : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // measure clock runs over n samples; skip first partial period
  task automatic measure(input int n, output int hi_min, output int hi_max,
                         output int per_min, output int per_max, output int lo_min,
                         output int pbad);
    bit prev, seen, p_at;
    int hi, lo, per;
    hi_min = 99; hi_max = 0; per_min = 99; per_max = 0; lo_min = 99; pbad = 0;
    seen = 0; hi = 0; lo = 0; per = 0; p_at = 0;
    @(negedge clk); prev = cpu;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      per++;
      if (cpu && !prev) begin
        if (seen) begin
          if (per < per_min) per_min = per;
          if (per > per_max) per_max = per;
          if (lo < lo_min) lo_min = lo;
          if (pclk == p_at) pbad++;
        end
        p_at = pclk; seen = 1; per = 0; hi = 0; lo = 0;
      end else if (seen && pclk != p_at) pbad++;
      if (cpu) hi++; else lo++;
      if (!cpu && prev && seen) begin
        if (hi < hi_min) hi_min = hi;
        if (hi > hi_max) hi_max = hi;
      end
      prev = cpu;
    end
  endtask

  initial begin
    #400000;
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int a, b, c, d, e, f, cnt, exp, osc_hi;
    bit prev, ok;
    wait_n(3);
    // R9 reset state
    chk(rst == 1 && cpu == 0 && pclk == 0 && rdy == 0 && osc == 0, "R9 init",
        {rst, cpu, pclk, rdy, osc}, 5'b10000);
    arst_n = 1;
    wait_n(10);
    chk(rst == 1, "R8 held while res_n low", rst, 1);

    // R8 release after power-on
    res_n = 1;
    wait_n(2);
    cnt = 0; prev = cpu;
    for (int i = 0; i < 40 && rst; i++) begin
      @(negedge clk);
      if (cpu && !prev) cnt++;
      prev = cpu;
    end
    chk(rst == 0 && cnt == 4, "R8 release count", cnt, 4);

    // R2/R3 crystal mode
    measure(40, a, b, c, d, e, f);
    chk(a == 1 && b == 1, "R2 xtal high width", b, 1);
    chk(c == 3 && d == 3, "R2 xtal period", d, 3);
    chk(f == 0, "R3 xtal pclk toggles", f, 0);
    // R4 crystal
    osc_hi = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); osc_hi += osc; end
    chk(osc_hi == 12, "R4 xtal osc", osc_hi, 12);

    // R5 sweep
    for (int v = 0; v < 16; v++) begin
      {rdy1, aen1_n, rdy2, aen2_n} = 4'(v);
      wait_n(8);
      exp = (v[3] & ~v[2]) | (v[1] & ~v[0]);
      chk(rdy == exp[0], $sformatf("R5 combo %0d", v), rdy, exp);
    end

    // R6 change lands on a falling processor clock
    for (int k = 0; k < 4; k++) begin
      {rdy1, aen1_n} = {~rdy, 1'b0}; rdy2 = 0;
      exp = rdy1;
      ok = 0; prev = cpu;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (rdy == exp[0]) begin ok = (prev && !cpu); break; end
        prev = cpu;
      end
      chk(ok, "R6 ready timing", ok, 1);
      wait_n(k + 1);
    end

    // R1 switch to external source mid-period
    wait_n(1);
    fsel = 1; efi_run = 1;
    measure(60, a, b, c, d, e, f);
    chk(a >= 1 && b <= 2 && e >= 2, "R1 no runt on switch", a, 1);
    measure(60, a, b, c, d, e, f);
    chk(a == 2 && b == 2, "R2 efi high width", b, 2);
    chk(c == 6 && d == 6, "R2 efi period", d, 6);
    chk(f == 0, "R3 efi pclk toggles", f, 0);
    osc_hi = 0; ok = 1; prev = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      osc_hi += osc;
      if (osc && prev) ok = 0;
      prev = osc;
    end
    chk(osc_hi == 10 && ok, "R4 efi osc", osc_hi, 10);

    // R1 back to crystal
    wait_n(2);
    fsel = 0;
    wait_n(12);
    efi_run = 0;
    measure(40, a, b, c, d, e, f);
    chk(a == 1 && b == 1 && c == 3 && d == 3, "R1 back to xtal", d, 3);

    // R7 assertion timing, R8 one-cycle pulse
    @(negedge clk); res_n = 0;
    @(negedge clk); res_n = 1;
    @(negedge clk);
    chk(rst == 0, "R7 not yet after two edges", rst, 0);
    @(negedge clk);
    chk(rst == 1, "R7 asserted after three edges", rst, 1);
    // edges so far since res_n rose: 2; count rises from third edge
    cnt = 0; prev = cpu;
    for (int i = 0; i < 40 && rst; i++) begin
      @(negedge clk);
      if (cpu && !prev) cnt++;
      prev = cpu;
    end
    chk(rst == 0 && cnt == 4, "R8 pulse release count", cnt, 4);

    // R8 long request keeps reset high
    res_n = 0;
    wait_n(30);
    chk(rst == 1, "R8 held during long request", rst, 1);
    res_n = 1;
    wait_n(40);
    chk(rst == 0, "R8 released after long request", rst, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule